// File: doc/BRIEF.md
# Amplifier power-down sequencer and enable pin

This block controls how a class-D output bridge shuts down. It takes an active-low hardware power-down pin and a power-down request from a register bit. When either one is active, it raises a fade-out request for the gain stage and counts clock cycles. When the count completes, it puts the bridge outputs into tristate by pulling its bridge-enable low.

A quick-off configuration bit lets the hardware pin tristate the bridge at once. A power-down requested through the register bit always waits the full count.

The block also drives a shared output pin. When the line-enable bit is clear, the pin carries the chip's fault/interrupt line. When the bit is set, the pin becomes an enable for an external line or headphone amplifier, with a programmable level and polarity. A mute flag rises when muting is enabled and the volume falls below -76 dB.

Top module: `pdn_sequencer`

## Requirements
- R1: While `rst_n` is low, at every clock edge `bridge_en`, `fade_req`, `mute` and `mpin` all go to 0.
- R2: `pwr_dn_pin_n` passes through a two-flop synchronizer. A level applied to the pin first affects the registered outputs at the third rising edge after it is applied.
- R3: With power-down active (synchronized pin low, or `reg_pwr_dn` high), `fade_req` is 1 at the next edge. `bridge_en` falls at the edge on which the DELAY-th consecutive cycle of power-down has been counted.
- R4: When `cfg_quick_off` is 1 and the synchronized hardware pin is low, `bridge_en` falls on the first edge at which that pin state is seen, without counting.
- R5: A power-down from `reg_pwr_dn` alone ignores `cfg_quick_off`. It always waits the full DELAY cycles.
- R6: If power-down is released before the count completes, the counter clears, `fade_req` drops and `bridge_en` stays 1. A later power-down counts the full DELAY again.
- R7: Once `bridge_en` is 0, it stays 0 while power-down lasts. It returns to 1 at the first edge at which no power-down request is present.
- R8: With `cfg_line_en` = 0, `mpin` follows the `fault_in` value sampled at the previous edge.
- R9: With `cfg_line_en` = 1 and no power-down, `mpin` is `cfg_line_lvl` XOR `cfg_line_pol`, registered.
- R10: With `cfg_line_en` = 1 and power-down active, `mpin` equals `cfg_line_pol`, registered.
- R11: `volume` is a two's-complement gain code in 0.5 dB steps (code -152 = -76 dB). `mute` is 1 one edge after `cfg_mute_en` = 1 and `volume` < -152 strictly. Otherwise it is 0.
- R12: The delay counter saturates at DELAY. `bridge_en` stays 0 for a power-down of any length beyond DELAY cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn_pin_n | input | 1 | Asynchronous hardware power-down pin, active low |
| reg_pwr_dn | input | 1 | Power-down request from a register bit, active high |
| cfg_quick_off | input | 1 | Tristate at once on a hardware power-down |
| cfg_line_en | input | 1 | Shared pin acts as the external amplifier enable |
| cfg_line_lvl | input | 1 | Enable level driven when not powered down |
| cfg_line_pol | input | 1 | Polarity: inverts the level, and is the value driven in power-down |
| cfg_mute_en | input | 1 | Enables low-volume muting |
| volume | input | VOL_W | Signed gain code, 0.5 dB per step |
| fault_in | input | 1 | Internal fault/interrupt line |
| bridge_en | output | 1 | Bridge enable, tristate when 0 |
| fade_req | output | 1 | Fade-out request to the gain stage |
| mute | output | 1 | Mute flag |
| mpin | output | 1 | Shared fault / amplifier-enable pin level |

## Verification
The bench builds the block with DELAY = 20 instead of the multi-million default. At that value a full countdown, release partway through the count, saturation after a long power-down, and a later re-arm with a cleared counter all complete within a few dozen cycles each. VOL_W stays at 9, so the codes on both sides of the -152 mute threshold, and the range ends, are reachable. A reference model that uses integers is compared with all four outputs on every cycle. This covers directed sequences and a long stretch of random pin, register and configuration changes.

// File: rtl/pdn_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the power-down sequencer.
// Assumes: nothing beyond plain synthesizable SystemVerilog.
package pdn_pkg;

    // Configuration of the shared fault / amplifier-enable pin
    typedef struct packed {
        logic en;   // pin acts as amplifier enable
        logic lvl;  // programmed level
        logic pol;  // polarity / power-down value
    } line_cfg_t;

    // Next level of the shared pin from configuration and state
    function automatic logic line_level(line_cfg_t cfg, logic pd, logic fault);
        if (!cfg.en)
            return fault;
        else if (pd)
            return cfg.pol;
        else
            return cfg.lvl ^ cfg.pol;
    endfunction

endpackage

// File: rtl/pdn_sync.sv
`timescale 1ns/1ps
// Module: multi-flop synchronizer for one asynchronous level.
// Assumes: the input is a slow level. RST_VAL is the idle level that reset loads.
module pdn_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[g] <= RST_VAL;
                    else        stage[g] <= din;
                end
            end else begin : g_next
                // Later stages resolve metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[g] <= RST_VAL;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage[STAGES-1];
endmodule

// File: rtl/pdn_countdown.sv
`timescale 1ns/1ps
// Module: power-down delay counter and bridge enable.
// Counts the cycles of continuous power-down and tristates the bridge when
// DELAY cycles have been counted, or at once on a quick hardware shutdown.
// Assumes: DELAY >= 1. pd_req and hw_pd are synchronous to clk.
module pdn_countdown #(
    parameter int DELAY = 13_000_000,
    localparam int CNT_W = $clog2(DELAY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_req,
    input  logic             hw_pd,
    input  logic             quick_off,
    output logic             bridge_en,
    output logic             fade_req,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(DELAY);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY - 1);

    logic quick_hit;
    logic count_done;

    assign quick_hit  = hw_pd && quick_off;
    assign count_done = (cnt >= CNT_LAST);

    // Saturating count of the cycles with power-down active
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!pd_req)      cnt <= '0;
        else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
    end

    // Bridge enable: sticky low during power-down, high without it
    always_ff @(posedge clk) begin
        if (!rst_n)      bridge_en <= 1'b0;
        else if (!pd_req) bridge_en <= 1'b1;
        else             bridge_en <= bridge_en && !(quick_hit || count_done);
    end

    // Fade-out request follows the power-down state
    always_ff @(posedge clk) begin
        if (!rst_n) fade_req <= 1'b0;
        else        fade_req <= pd_req;
    end
endmodule

// File: rtl/pdn_outmux.sv
`timescale 1ns/1ps
// Module: shared pin selection and low-volume mute flag.
// Assumes: volume is a signed gain code in half-dB steps. MUTE_CODE fits in VOL_W.
module pdn_outmux
    import pdn_pkg::*;
#(
    parameter int        VOL_W     = 9,
    parameter int signed MUTE_CODE = -152
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  line_cfg_t               line_cfg,
    input  logic                    pd_req,
    input  logic                    fault_in,
    input  logic                    mute_en,
    input  logic signed [VOL_W-1:0] volume,
    output logic                    mpin,
    output logic                    mute
);
    localparam logic signed [VOL_W-1:0] MUTE_LIM = MUTE_CODE[VOL_W-1:0];

    logic below_lim;
    assign below_lim = (volume < MUTE_LIM);

    // Registered level of the shared pin
    always_ff @(posedge clk) begin
        if (!rst_n) mpin <= 1'b0;
        else        mpin <= line_level(line_cfg, pd_req, fault_in);
    end

    // Registered mute flag on strict below-threshold volume
    always_ff @(posedge clk) begin
        if (!rst_n) mute <= 1'b0;
        else        mute <= mute_en && below_lim;
    end
endmodule

// File: rtl/pdn_sequencer.sv
`timescale 1ns/1ps
// Module: amplifier power-down sequencer, top level.
// Merges the hardware pin and the register request, sequences the bridge
// shutdown, and drives the shared pin and the mute flag.
// Assumes: the pin is asynchronous. All other inputs are synchronous to clk.
module pdn_sequencer
    import pdn_pkg::*;
#(
    parameter int        DELAY       = 13_000_000,
    parameter int        SYNC_STAGES = 2,
    parameter int        VOL_W       = 9,
    parameter int signed MUTE_CODE   = -152,
    localparam int       CNT_W       = $clog2(DELAY + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pwr_dn_pin_n,
    input  logic                    reg_pwr_dn,
    input  logic                    cfg_quick_off,
    input  logic                    cfg_line_en,
    input  logic                    cfg_line_lvl,
    input  logic                    cfg_line_pol,
    input  logic                    cfg_mute_en,
    input  logic signed [VOL_W-1:0] volume,
    input  logic                    fault_in,
    output logic                    bridge_en,
    output logic                    fade_req,
    output logic                    mute,
    output logic                    mpin
);
    logic             pin_sync_n;
    logic             hw_pd;
    logic             pd_req;
    logic [CNT_W-1:0] cnt;
    line_cfg_t        line_cfg;

    // Synchronize the hardware pin (idle high)
    pdn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pwr_dn_pin_n),
        .dout  (pin_sync_n)
    );

    // Merge the two power-down sources
    assign hw_pd  = !pin_sync_n;
    assign pd_req = hw_pd || reg_pwr_dn;

    assign line_cfg = '{en: cfg_line_en, lvl: cfg_line_lvl, pol: cfg_line_pol};

    pdn_countdown #(.DELAY(DELAY)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_req    (pd_req),
        .hw_pd     (hw_pd),
        .quick_off (cfg_quick_off),
        .bridge_en (bridge_en),
        .fade_req  (fade_req),
        .cnt       (cnt)
    );

    pdn_outmux #(.VOL_W(VOL_W), .MUTE_CODE(MUTE_CODE)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_cfg (line_cfg),
        .pd_req   (pd_req),
        .fault_in (fault_in),
        .mute_en  (cfg_mute_en),
        .volume   (volume),
        .mpin     (mpin),
        .mute     (mute)
    );
endmodule

// File: rtl/pdn_sequencer_chk.sv
`timescale 1ns/1ps
// Module: property checker for pdn_sequencer, attached by bind.
// Assumes: it observes the synchronized pin state and the counter of the top.
module pdn_sequencer_chk #(
    parameter int DELAY = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hw_pd,
    input logic             pd_req,
    input logic             reg_pwr_dn,
    input logic             quick_off,
    input logic             fault_in,
    input logic             line_en,
    input logic             line_pol,
    input logic             mute_en,
    input logic [CNT_W-1:0] cnt,
    input logic             bridge_en,
    input logic             fade_req,
    input logic             mpin,
    input logic             mute
);
    // R3: power-down raises the fade request at the next edge
    a_r3_fade_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |=> fade_req);

    // R4: a quick hardware shutdown tristates at once
    a_r4_quick_off: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_pd && quick_off) |=> !bridge_en);

    // R5: a register power-down alone keeps the bridge on until the count ends
    a_r5_reg_full_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_pwr_dn && !hw_pd && bridge_en && (cnt < CNT_W'(DELAY - 1))) |=> bridge_en);

    // R6: release clears the count and drops the fade request (R7: bridge back on)
    a_r6_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_req |=> (bridge_en && !fade_req && (cnt == '0)));

    // R8: with the enable function off, the pin carries the fault line
    a_r8_fault_line: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en |=> (mpin == $past(fault_in)));

    // R10: in power-down with the enable function on, the pin equals the polarity bit
    a_r10_pd_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en && pd_req) |=> (mpin == $past(line_pol)));

    // R11: with muting disabled, no mute flag
    a_r11_mute_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_en |=> !mute);

    // R12: the counter never passes its terminal value
    a_r12_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DELAY));
endmodule

bind pdn_sequencer pdn_sequencer_chk #(.DELAY(DELAY), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_pd      (hw_pd),
    .pd_req     (pd_req),
    .reg_pwr_dn (reg_pwr_dn),
    .quick_off  (cfg_quick_off),
    .fault_in   (fault_in),
    .line_en    (cfg_line_en),
    .line_pol   (cfg_line_pol),
    .mute_en    (cfg_mute_en),
    .cnt        (cnt),
    .bridge_en  (bridge_en),
    .fade_req   (fade_req),
    .mpin       (mpin),
    .mute       (mute)
);

// File: tb/test_pdn_sequencer.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus directed checks.
module test_pdn_sequencer;
    localparam int DELAY = 20;
    localparam int VOL_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_dn_pin_n = 1'b1;
    logic reg_pwr_dn = 1'b0;
    logic cfg_quick_off = 1'b0;
    logic cfg_line_en = 1'b0;
    logic cfg_line_lvl = 1'b0;
    logic cfg_line_pol = 1'b0;
    logic cfg_mute_en = 1'b0;
    logic signed [VOL_W-1:0] volume = '0;
    logic fault_in = 1'b0;
    logic bridge_en, fade_req, mute, mpin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_pin_hist[$];
    int m_cnt = 0;
    int m_br = 0, m_fade = 0, m_mute = 0, m_mpin = 0;
    bit m_valid = 1'b0;

    always #5 clk = ~clk;

    pdn_sequencer #(.DELAY(DELAY), .VOL_W(VOL_W)) i_pdn_sequencer (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_dn_pin_n  (pwr_dn_pin_n),
        .reg_pwr_dn    (reg_pwr_dn),
        .cfg_quick_off (cfg_quick_off),
        .cfg_line_en   (cfg_line_en),
        .cfg_line_lvl  (cfg_line_lvl),
        .cfg_line_pol  (cfg_line_pol),
        .cfg_mute_en   (cfg_mute_en),
        .volume        (volume),
        .fault_in      (fault_in),
        .bridge_en     (bridge_en),
        .fade_req      (fade_req),
        .mute          (mute),
        .mpin          (mpin)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: the pin is seen two edges late; outputs follow the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pin_hist = '{1, 1};
            m_cnt = 0; m_br = 0; m_fade = 0; m_mute = 0; m_mpin = 0;
        end else begin
            int hw, pd;
            hw = (m_pin_hist[0] == 0) ? 1 : 0;
            pd = (hw != 0 || reg_pwr_dn) ? 1 : 0;
            if (pd == 0) begin
                m_br = 1; m_cnt = 0;
            end else begin
                if (m_cnt < DELAY) m_cnt = m_cnt + 1;
                if ((hw != 0 && cfg_quick_off) || m_cnt >= DELAY) m_br = 0;
            end
            m_fade = pd;
            if (!cfg_line_en)  m_mpin = fault_in;
            else if (pd != 0)  m_mpin = cfg_line_pol;
            else               m_mpin = cfg_line_lvl ^ cfg_line_pol;
            m_mute = (cfg_mute_en && (int'(volume) < -152)) ? 1 : 0;
            void'(m_pin_hist.pop_front());
            m_pin_hist.push_back(pwr_dn_pin_n);
        end
        m_valid = 1'b1;
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (m_valid && !done) begin
            chk("R3 model bridge_en", bridge_en, m_br);
            chk("R3 model fade_req", fade_req, m_fade);
            chk("R11 model mute", mute, m_mute);
            chk("R9 model mpin", mpin, m_mpin);
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R1: reset state
        chk("R1 bridge_en", bridge_en, 0);
        chk("R1 fade_req", fade_req, 0);
        chk("R1 mpin", mpin, 0);
        rst_n = 1'b1;
        cyc(1);
        chk("R7 bridge on after reset", bridge_en, 1);
        cyc(3);

        // R2, R3: hardware pin, full count
        pwr_dn_pin_n = 1'b0;
        cyc(2);
        chk("R2 fade not yet", fade_req, 0);
        cyc(1);
        chk("R3 fade raised", fade_req, 1);
        cyc(DELAY - 2);
        chk("R3 bridge still on", bridge_en, 1);
        cyc(1);
        chk("R3 bridge tristate", bridge_en, 0);
        cyc(30);
        chk("R12 stays off", bridge_en, 0);
        pwr_dn_pin_n = 1'b1;
        cyc(2);
        chk("R7 still off in sync", bridge_en, 0);
        cyc(1);
        chk("R7 re-enabled", bridge_en, 1);
        cyc(3);

        // R4: quick off on the hardware pin
        cfg_quick_off = 1'b1;
        pwr_dn_pin_n = 1'b0;
        cyc(2);
        chk("R4 before sync", bridge_en, 1);
        cyc(1);
        chk("R4 quick tristate", bridge_en, 0);
        pwr_dn_pin_n = 1'b1;
        cyc(5);

        // R5: register request ignores quick off
        reg_pwr_dn = 1'b1;
        cyc(DELAY - 1);
        chk("R5 bridge on during count", bridge_en, 1);
        cyc(1);
        chk("R5 bridge off after count", bridge_en, 0);
        reg_pwr_dn = 1'b0;
        cfg_quick_off = 1'b0;
        cyc(3);

        // R6: release mid count then re-arm
        reg_pwr_dn = 1'b1;
        cyc(5);
        reg_pwr_dn = 1'b0;
        cyc(1);
        chk("R6 fade dropped", fade_req, 0);
        chk("R6 bridge kept on", bridge_en, 1);
        cyc(DELAY);
        chk("R6 bridge on later", bridge_en, 1);
        reg_pwr_dn = 1'b1;
        cyc(DELAY - 1);
        chk("R6 full count again", bridge_en, 1);
        cyc(1);
        chk("R6 tristate after full count", bridge_en, 0);
        reg_pwr_dn = 1'b0;
        cyc(2);

        // R8: fault line
        fault_in = 1'b1;
        cyc(1);
        chk("R8 fault high", mpin, 1);
        fault_in = 1'b0;
        cyc(1);
        chk("R8 fault low", mpin, 0);

        // R9: level xor polarity
        cfg_line_en = 1'b1;
        fault_in = 1'b1;
        for (int k = 0; k < 4; k++) begin
            cfg_line_lvl = k[0];
            cfg_line_pol = k[1];
            cyc(1);
            chk("R9 level xor pol", mpin, k[0] ^ k[1]);
        end

        // R10: polarity forced in power-down
        reg_pwr_dn = 1'b1;
        cfg_line_lvl = 1'b1;
        cfg_line_pol = 1'b0;
        cyc(1);
        chk("R10 pd pol0", mpin, 0);
        cfg_line_pol = 1'b1;
        cfg_line_lvl = 1'b0;
        cyc(1);
        chk("R10 pd pol1", mpin, 1);
        reg_pwr_dn = 1'b0;
        cfg_line_en = 1'b0;
        fault_in = 1'b0;
        cyc(2);

        // R11: strict threshold
        cfg_mute_en = 1'b1;
        volume = -9'sd152;
        cyc(1);
        chk("R11 at threshold", mute, 0);
        volume = -9'sd153;
        cyc(1);
        chk("R11 below threshold", mute, 1);
        volume = -9'sd256;
        cyc(1);
        chk("R11 minimum code", mute, 1);
        cfg_mute_en = 1'b0;
        cyc(1);
        chk("R11 disabled", mute, 0);
        cfg_mute_en = 1'b1;
        volume = 9'sd255;
        cyc(1);
        chk("R11 loud", mute, 0);

        // Random stretch compared against the model
        for (int i = 0; i < 4000; i++) begin
            int v;
            if ($urandom_range(0, 15) == 0) pwr_dn_pin_n = ~pwr_dn_pin_n;
            if ($urandom_range(0, 19) == 0) reg_pwr_dn = ~reg_pwr_dn;
            if ($urandom_range(0, 31) == 0) cfg_quick_off = ~cfg_quick_off;
            cfg_line_en  = $urandom_range(0, 3) != 0;
            cfg_line_lvl = 1'($urandom_range(0, 1));
            cfg_line_pol = 1'($urandom_range(0, 1));
            cfg_mute_en  = 1'($urandom_range(0, 1));
            fault_in     = 1'($urandom_range(0, 1));
            v = $urandom_range(0, 40) + 132;
            volume = VOL_W'(-v);
            if (i == 2000) begin
                rst_n = 1'b0;
                cyc(2);
                rst_n = 1'b1;
            end
            cyc(1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule